// File: doc/BRIEF.md
# Transactional Memory Conflict Tracker

This block follows a single hardware memory transaction on a core. While a transaction is open it records each cache line the core loads from or stores to. Lines are kept in a small table that is indexed by line address. Every entry holds a read flag and a write flag, plus the most recent store data for that line. The core's stores stay inside the table. Other agents see them only when the transaction commits. At commit, every written line is presented on a wide output for exactly one cycle, and the table is then emptied.

The block also watches three other inputs: snoops from other agents, line evictions, and exception events. Conflicts are decided only by whether line addresses overlap, and a write must be involved. A remote write to a line that this transaction has written therefore aborts it, even when the bytes are the same. The transaction also aborts when:
- a written line is evicted;
- an interrupt or fault arrives;
- the table has no free entry for a new line;
- the core issues an explicit abort.

On abort, all buffered data is dropped, and a one-cycle pulse carries a 3-bit cause code.

Top module: `tm_conflict_tracker`

## Requirements
- R1: A begin command while idle opens a transaction, and `tx_active` is 1 from the next cycle. A begin while a transaction is open is ignored.
- R2: Commit or abort commands while no transaction is open produce no pulse and leave the block idle.
- R3: Matching uses the line address `addr[ADDR_W-1:LINE_BITS]`; the low LINE_BITS bits (6 by default, 64-byte lines) are ignored. The commit tag of an entry is that line address.
- R4: Conflict rules, checked only against lines already tracked:
  - A remote write that hits any tracked line aborts with cause 1 (conflict).
  - A remote read that hits a written line aborts with cause 1.
  - A remote read that hits a read-only line, or any remote access to an untracked line, has no effect.
- R5: A remote write to a line in the write set aborts with cause 1 even when it carries the same data that was stored.
- R6: Stores are held locally, and `commit_mask`, `commit_tags` and `commit_data` read zero except in the single commit cycle. In that cycle, bit i of `commit_mask` marks entry i as written, and entry i holds the i-th distinct line touched. A later store to the same line replaces that entry's data.
- R7: Evicting a written line aborts with cause 3. Evicting a read-only or untracked line has no effect.
- R8: An exception event (interrupt, fault or unsupported operation) during a transaction aborts with cause 4.
- R9: An access to a new line when all ENTRIES entries are in use aborts with cause 2. An access to an already-tracked line while the table is full proceeds normally.
- R10: An explicit abort aborts with cause 5. All buffered lines are discarded, so a later transaction neither commits them nor conflicts on them.
- R11: If several abort causes occur in one cycle, the reported cause follows this priority: conflict, then eviction, then capacity, then exception, then explicit. Any abort cause in the commit cycle cancels the commit.
- R12: Committing clears both sets, so a following transaction does not conflict on lines of the committed one.
- R13: `abort_pulse` and `commit_pulse` last one cycle and appear in the cycle after the triggering edge, and that same edge clears `tx_active`. `abort_cause` is 0 outside an abort pulse. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Open a transaction |
| cmd_commit | input | 1 | Commit the open transaction |
| cmd_abort | input | 1 | Explicitly abort the open transaction |
| loc_valid | input | 1 | Local core access this cycle |
| loc_write | input | 1 | Local access is a store |
| loc_addr | input | ADDR_W | Physical address of local access |
| loc_wdata | input | DATA_W | Store data of local access |
| snp_valid | input | 1 | Remote snoop this cycle |
| snp_write | input | 1 | Remote snoop is a write |
| snp_addr | input | ADDR_W | Physical address of remote access |
| evict_valid | input | 1 | Line eviction notice |
| evict_addr | input | ADDR_W | Physical address of evicted line |
| exc_event | input | 1 | Interrupt, fault or unsupported-operation event |
| tx_active | output | 1 | Transaction open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 3 | 1 conflict, 2 capacity, 3 eviction, 4 exception, 5 explicit |
| commit_pulse | output | 1 | One-cycle commit indication |
| commit_mask | output | ENTRIES | Written entries published at commit |
| commit_tags | output | ENTRIES*(ADDR_W-LINE_BITS) | Line addresses, entry i at slice i |
| commit_data | output | ENTRIES*DATA_W | Buffered store data, entry i at slice i |

## Verification
The bench builds the block with eight entries, 32-bit addresses, 32-bit data and 64-byte lines. Eight entries keep the table small enough that a ninth distinct line, the capacity abort, and a hit on an existing line while the table is full can all be reached within a dozen cycles. The 32-bit address leaves 26 tag bits. Addresses that differ only in their offset bits are used to show that matching happens at line granularity. Same-cycle combinations of snoop, exception, abort and commit reach the cause priority and the abort-over-commit rule.

// File: rtl/tm_tracker_pkg.sv
package tm_tracker_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_CONFLICT = 3'd1,
    CAUSE_CAPACITY = 3'd2,
    CAUSE_EVICT    = 3'd3,
    CAUSE_EXCEPT   = 3'd4,
    CAUSE_EXPLICIT = 3'd5
  } tm_cause_e;

  // a remote access collides with a tracked line when a write is involved
  function automatic logic snoop_collides(input logic remote_wr,
                                          input logic line_rd,
                                          input logic line_wr);
    return line_wr | (remote_wr & line_rd);
  endfunction

  // an eviction only matters for a line the transaction has written
  function automatic logic evict_hurts(input logic line_wr);
    return line_wr;
  endfunction

endpackage

// File: rtl/tm_line_set.sv
module tm_line_set #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 34,
  parameter int DATA_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      upd_en,
  input  logic                      upd_write,
  input  logic [TAG_W-1:0]          upd_tag,
  input  logic [DATA_W-1:0]         upd_data,
  input  logic [TAG_W-1:0]          snp_tag,
  input  logic [TAG_W-1:0]          evict_tag,
  output logic                      upd_hit,
  output logic                      full,
  output logic [ENTRIES-1:0]        rd_vec,
  output logic [ENTRIES-1:0]        wr_vec,
  output logic [ENTRIES-1:0]        snp_hit_vec,
  output logic [ENTRIES-1:0]        evict_hit_vec,
  output logic [ENTRIES*TAG_W-1:0]  tags_flat,
  output logic [ENTRIES*DATA_W-1:0] data_flat
);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] upd_hit_vec;
  logic [ENTRIES-1:0] alloc_oh;
  logic               alloc_found;

  // lowest free entry takes the next new line, so entry order is first-touch order
  always_comb begin
    alloc_oh    = '0;
    alloc_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld[i] && !alloc_found) begin
        alloc_oh[i] = 1'b1;
        alloc_found = 1'b1;
      end
    end
  end

  assign upd_hit = |upd_hit_vec;
  assign full    = &vld;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              v_q;
    logic              r_q;
    logic              w_q;
    logic              sel;

    assign upd_hit_vec[g]   = v_q && (tag_q == upd_tag);
    assign snp_hit_vec[g]   = v_q && (tag_q == snp_tag);
    assign evict_hit_vec[g] = v_q && (tag_q == evict_tag);
    assign sel = upd_en && (upd_hit_vec[g] || (!upd_hit && alloc_oh[g]));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        v_q    <= 1'b0;
        r_q    <= 1'b0;
        w_q    <= 1'b0;
        tag_q  <= '0;
        data_q <= '0;
      end else if (sel) begin
        v_q   <= 1'b1;
        tag_q <= upd_tag;
        if (upd_write) begin
          w_q    <= 1'b1;
          data_q <= upd_data;
        end else begin
          r_q <= 1'b1;
        end
      end
    end

    assign vld[g]    = v_q;
    assign rd_vec[g] = r_q;
    assign wr_vec[g] = w_q;
    assign tags_flat[g*TAG_W +: TAG_W]    = tag_q;
    assign data_flat[g*DATA_W +: DATA_W]  = data_q;
  end

endmodule

// File: rtl/tm_cause_pick.sv
module tm_cause_pick
  import tm_tracker_pkg::*;
(
  input  logic      conflict_ev,
  input  logic      evict_ev,
  input  logic      cap_ev,
  input  logic      exc_ev,
  input  logic      expl_ev,
  output logic      abort_any,
  output tm_cause_e cause
);

  assign abort_any = conflict_ev | evict_ev | cap_ev | exc_ev | expl_ev;

  always_comb begin
    if (conflict_ev)   cause = CAUSE_CONFLICT;
    else if (evict_ev) cause = CAUSE_EVICT;
    else if (cap_ev)   cause = CAUSE_CAPACITY;
    else if (exc_ev)   cause = CAUSE_EXCEPT;
    else if (expl_ev)  cause = CAUSE_EXPLICIT;
    else               cause = CAUSE_NONE;
  end

endmodule

// File: rtl/tm_conflict_tracker.sv
module tm_conflict_tracker
  import tm_tracker_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 64,
  parameter int ENTRIES   = 8,
  parameter int LINE_BITS = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_begin,
  input  logic                                  cmd_commit,
  input  logic                                  cmd_abort,
  input  logic                                  loc_valid,
  input  logic                                  loc_write,
  input  logic [ADDR_W-1:0]                     loc_addr,
  input  logic [DATA_W-1:0]                     loc_wdata,
  input  logic                                  snp_valid,
  input  logic                                  snp_write,
  input  logic [ADDR_W-1:0]                     snp_addr,
  input  logic                                  evict_valid,
  input  logic [ADDR_W-1:0]                     evict_addr,
  input  logic                                  exc_event,
  output logic                                  tx_active,
  output logic                                  abort_pulse,
  output logic [2:0]                            abort_cause,
  output logic                                  commit_pulse,
  output logic [ENTRIES-1:0]                    commit_mask,
  output logic [ENTRIES*(ADDR_W-LINE_BITS)-1:0] commit_tags,
  output logic [ENTRIES*DATA_W-1:0]             commit_data
);

  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic [TAG_W-1:0] loc_tag;
  logic [TAG_W-1:0] snp_tag;
  logic [TAG_W-1:0] evict_tag;
  logic             unused_offsets;

  assign loc_tag   = loc_addr[ADDR_W-1:LINE_BITS];
  assign snp_tag   = snp_addr[ADDR_W-1:LINE_BITS];
  assign evict_tag = evict_addr[ADDR_W-1:LINE_BITS];
  assign unused_offsets = ^{loc_addr[LINE_BITS-1:0], snp_addr[LINE_BITS-1:0],
                            evict_addr[LINE_BITS-1:0]};

  // named events, also observed by the checker
  logic      upd_en;
  logic      upd_hit;
  logic      full;
  logic      conflict_ev;
  logic      evict_ev;
  logic      cap_ev;
  logic      exc_ev;
  logic      expl_ev;
  logic      abort_now;
  logic      commit_now;
  logic      begin_now;
  tm_cause_e cause_now;

  logic [ENTRIES-1:0]        rd_vec;
  logic [ENTRIES-1:0]        wr_vec;
  logic [ENTRIES-1:0]        snp_hit_vec;
  logic [ENTRIES-1:0]        evict_hit_vec;
  logic [ENTRIES*TAG_W-1:0]  tags_flat;
  logic [ENTRIES*DATA_W-1:0] data_flat;

  // a local access in the commit cycle is not recorded
  assign upd_en = tx_active && loc_valid && !cmd_commit;

  tm_line_set #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_set (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (abort_now || commit_now),
    .upd_en        (upd_en),
    .upd_write     (loc_write),
    .upd_tag       (loc_tag),
    .upd_data      (loc_wdata),
    .snp_tag       (snp_tag),
    .evict_tag     (evict_tag),
    .upd_hit       (upd_hit),
    .full          (full),
    .rd_vec        (rd_vec),
    .wr_vec        (wr_vec),
    .snp_hit_vec   (snp_hit_vec),
    .evict_hit_vec (evict_hit_vec),
    .tags_flat     (tags_flat),
    .data_flat     (data_flat)
  );

  always_comb begin
    logic coll;
    logic hurt;
    coll = 1'b0;
    hurt = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      coll = coll | (snp_hit_vec[i] & snoop_collides(snp_write, rd_vec[i], wr_vec[i]));
      hurt = hurt | (evict_hit_vec[i] & evict_hurts(wr_vec[i]));
    end
    conflict_ev = tx_active && snp_valid && coll;
    evict_ev    = tx_active && evict_valid && hurt;
  end

  assign cap_ev  = upd_en && !upd_hit && full;
  assign exc_ev  = tx_active && exc_event;
  assign expl_ev = tx_active && cmd_abort;

  tm_cause_pick u_pick (
    .conflict_ev (conflict_ev),
    .evict_ev    (evict_ev),
    .cap_ev      (cap_ev),
    .exc_ev      (exc_ev),
    .expl_ev     (expl_ev),
    .abort_any   (abort_now),
    .cause       (cause_now)
  );

  assign commit_now = tx_active && cmd_commit && !abort_now;
  assign begin_now  = !tx_active && cmd_begin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active    <= 1'b0;
      abort_pulse  <= 1'b0;
      abort_cause  <= CAUSE_NONE;
      commit_pulse <= 1'b0;
      commit_mask  <= '0;
      commit_tags  <= '0;
      commit_data  <= '0;
    end else begin
      if (begin_now)                    tx_active <= 1'b1;
      else if (abort_now || commit_now) tx_active <= 1'b0;
      abort_pulse  <= abort_now;
      abort_cause  <= abort_now ? cause_now : CAUSE_NONE;
      commit_pulse <= commit_now;
      commit_mask  <= commit_now ? wr_vec    : '0;
      commit_tags  <= commit_now ? tags_flat : '0;
      commit_data  <= commit_now ? data_flat : '0;
    end
  end

endmodule

// File: rtl/tm_tracker_chk.sv
module tm_tracker_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_active,
  input logic               abort_pulse,
  input logic [2:0]         abort_cause,
  input logic               commit_pulse,
  input logic [ENTRIES-1:0] commit_mask,
  input logic               conflict_ev,
  input logic               evict_ev,
  input logic               cap_ev,
  input logic               exc_ev,
  input logic               expl_ev
);

  AST_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_ev |=> abort_pulse && abort_cause == 3'd1); // R4

  AST_EVICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev && !conflict_ev |=> abort_pulse && abort_cause == 3'd3); // R7

  AST_CAPACITY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev && !conflict_ev && !evict_ev |=> abort_pulse && abort_cause == 3'd2); // R9

  AST_EXCEPT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ev && !conflict_ev && !evict_ev && !cap_ev |=> abort_cause == 3'd4); // R8

  AST_EXPLICIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    expl_ev && !conflict_ev && !evict_ev && !cap_ev && !exc_ev |=> abort_cause == 3'd5); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> !abort_pulse && !commit_pulse); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && commit_pulse)); // R11

  AST_PULSE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse || commit_pulse |-> !tx_active); // R13

  AST_CAUSE_ONLY_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> abort_cause == 3'd0); // R13

  AST_MASK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |-> commit_mask == '0); // R6

endmodule

bind tm_conflict_tracker tm_tracker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_active    (tx_active),
  .abort_pulse  (abort_pulse),
  .abort_cause  (abort_cause),
  .commit_pulse (commit_pulse),
  .commit_mask  (commit_mask),
  .conflict_ev  (conflict_ev),
  .evict_ev     (evict_ev),
  .cap_ev       (cap_ev),
  .exc_ev       (exc_ev),
  .expl_ev      (expl_ev)
);

// File: tb/test_tm_conflict_tracker.sv
module test_tm_conflict_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int ENTRIES    = 8;
  localparam int LINE_BITS  = 6;
  localparam int TAG_W      = ADDR_W - LINE_BITS;

  // op codes used by the vector table
  localparam logic [3:0] OP_BEG = 4'd1, OP_LD = 4'd2, OP_ST = 4'd3, OP_SR = 4'd4,
                         OP_SW = 4'd5, OP_EV = 4'd6, OP_EX = 4'd7, OP_CM = 4'd8,
                         OP_AB = 4'd9;

  // row: op, addr, data, exp active, exp abort, exp cause, exp commit, exp mask, req
  localparam int ROW_W  = 46;
  localparam int N_ROWS = 43;
  localparam logic [ROW_W-1:0] ROWS [N_ROWS] = '{
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1 ignored
    {OP_ST,  16'h0040, 8'hAA, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd6},  // R6
    {OP_LD,  16'h0080, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd3},  // R3
    {OP_SR,  16'h00BF, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd4},  // R4 read-only hit
    {OP_SR,  16'h0100, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd4},  // R4 untracked
    {OP_EV,  16'h0080, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd7},  // R7 read-only evict
    {OP_ST,  16'h007F, 8'hBB, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd3},  // R3 same line
    {OP_CM,  16'h0000, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h01, 4'd6},  // R6
    {OP_CM,  16'h0000, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 4'd2},  // R2
    {OP_AB,  16'h0000, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 4'd2},  // R2
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_SW,  16'h0040, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd12}, // R12
    {OP_LD,  16'h0040, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd4},  // R4
    {OP_SW,  16'h0040, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 8'h00, 4'd4},  // R4 write on read set
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_ST,  16'h0200, 8'h11, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd6},  // R6
    {OP_SR,  16'h0200, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 8'h00, 4'd4},  // R4 read on write set
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_ST,  16'h0300, 8'h22, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd6},  // R6
    {OP_SW,  16'h0300, 8'h22, 1'b0, 1'b1, 3'd1, 1'b0, 8'h00, 4'd5},  // R5 same data
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_ST,  16'h0400, 8'h33, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd6},  // R6
    {OP_EV,  16'h0400, 8'h00, 1'b0, 1'b1, 3'd3, 1'b0, 8'h00, 4'd7},  // R7
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_EX,  16'h0000, 8'h00, 1'b0, 1'b1, 3'd4, 1'b0, 8'h00, 4'd8},  // R8
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_ST,  16'h0500, 8'h44, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd6},  // R6
    {OP_AB,  16'h0000, 8'h00, 1'b0, 1'b1, 3'd5, 1'b0, 8'h00, 4'd10}, // R10
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1},  // R1
    {OP_SR,  16'h0500, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd10}, // R10 discarded
    {OP_CM,  16'h0000, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 4'd10}, // R10 empty commit
    {OP_BEG, 16'h0000, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0400, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0440, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0480, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h04C0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0500, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0540, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h0580, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9
    {OP_LD,  16'h05C0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9 table full
    {OP_LD,  16'h0440, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd9},  // R9 hit while full
    {OP_LD,  16'h0600, 8'h00, 1'b0, 1'b1, 3'd2, 1'b0, 8'h00, 4'd9}   // R9 ninth line
  };

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic                      cmd_begin, cmd_commit, cmd_abort;
  logic                      loc_valid, loc_write;
  logic [ADDR_W-1:0]         loc_addr;
  logic [DATA_W-1:0]         loc_wdata;
  logic                      snp_valid, snp_write;
  logic [ADDR_W-1:0]         snp_addr;
  logic                      evict_valid;
  logic [ADDR_W-1:0]         evict_addr;
  logic                      exc_event;
  logic                      tx_active, abort_pulse, commit_pulse;
  logic [2:0]                abort_cause;
  logic [ENTRIES-1:0]        commit_mask;
  logic [ENTRIES*TAG_W-1:0]  commit_tags;
  logic [ENTRIES*DATA_W-1:0] commit_data;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tm_conflict_tracker #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .ENTRIES (ENTRIES), .LINE_BITS (LINE_BITS)
  ) i_tm_conflict_tracker (
    .clk (clk), .rst_n (rst_n),
    .cmd_begin (cmd_begin), .cmd_commit (cmd_commit), .cmd_abort (cmd_abort),
    .loc_valid (loc_valid), .loc_write (loc_write), .loc_addr (loc_addr),
    .loc_wdata (loc_wdata),
    .snp_valid (snp_valid), .snp_write (snp_write), .snp_addr (snp_addr),
    .evict_valid (evict_valid), .evict_addr (evict_addr), .exc_event (exc_event),
    .tx_active (tx_active), .abort_pulse (abort_pulse), .abort_cause (abort_cause),
    .commit_pulse (commit_pulse), .commit_mask (commit_mask),
    .commit_tags (commit_tags), .commit_data (commit_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic quiet();
    cmd_begin = 0; cmd_commit = 0; cmd_abort = 0;
    loc_valid = 0; loc_write = 0; loc_addr = '0; loc_wdata = '0;
    snp_valid = 0; snp_write = 0; snp_addr = '0;
    evict_valid = 0; evict_addr = '0; exc_event = 0;
  endtask

  // drive at a falling edge, results are sampled at the next falling edge
  task automatic drive_op(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d);
    quiet();
    case (op)
      OP_BEG: cmd_begin = 1;
      OP_LD:  begin loc_valid = 1; loc_addr = a; end
      OP_ST:  begin loc_valid = 1; loc_write = 1; loc_addr = a; loc_wdata = d; end
      OP_SR:  begin snp_valid = 1; snp_addr = a; end
      OP_SW:  begin snp_valid = 1; snp_write = 1; snp_addr = a; end
      OP_EV:  begin evict_valid = 1; evict_addr = a; end
      OP_EX:  exc_event = 1;
      OP_CM:  cmd_commit = 1;
      OP_AB:  cmd_abort = 1;
      default: ;
    endcase
  endtask

  task automatic step(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    drive_op(op, a, d);
    @(negedge clk);
    quiet();
  endtask

  task automatic check_outcome(input string req, input logic act, input logic ab,
                               input logic [2:0] cause, input logic cm,
                               input logic [7:0] mask);
    chk(req, "tx_active", 64'(tx_active), 64'(act));
    chk(req, "abort_pulse", 64'(abort_pulse), 64'(ab));
    chk(req, "abort_cause", 64'(abort_cause), 64'(cause));
    chk(req, "commit_pulse", 64'(commit_pulse), 64'(cm));
    chk(req, "commit_mask", 64'(commit_mask), 64'(mask));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check_outcome("R13 reset", 1'b0, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R13 reset", "commit_tags", 64'(commit_tags[TAG_W-1:0]), 64'd0);
    chk("R13 reset", "commit_data", 64'(commit_data[DATA_W-1:0]), 64'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N_ROWS; i++) begin
      logic [ROW_W-1:0] r;
      r = ROWS[i];
      step(r[45:42], ADDR_W'(r[41:26]), DATA_W'(r[25:18]));
      check_outcome($sformatf("R%0d row %0d", r[3:0], i),
                    r[17], r[16], r[15:13], r[12], r[11:4]);
    end

    // R11 conflict outranks exception and explicit abort, and cancels commit
    step(OP_BEG, '0, '0);
    step(OP_ST, 32'h0800, 32'h1);
    drive_op(OP_SW, 32'h0800, '0);
    exc_event = 1; cmd_abort = 1; cmd_commit = 1;
    @(negedge clk);
    quiet();
    check_outcome("R11 conflict first", 1'b0, 1'b1, 3'd1, 1'b0, 8'h00);

    // R11 eviction outranks capacity-free exception
    step(OP_BEG, '0, '0);
    step(OP_ST, 32'h0840, 32'h2);
    drive_op(OP_EV, 32'h0840, '0);
    exc_event = 1;
    @(negedge clk);
    quiet();
    check_outcome("R11 evict over exception", 1'b0, 1'b1, 3'd3, 1'b0, 8'h00);

    // R11 exception in the commit cycle wins over commit
    step(OP_BEG, '0, '0);
    step(OP_ST, 32'h0840, 32'h3);
    drive_op(OP_CM, '0, '0);
    exc_event = 1;
    @(negedge clk);
    quiet();
    check_outcome("R11 abort beats commit", 1'b0, 1'b1, 3'd4, 1'b0, 8'h00);

    // R6 / R3 published lines, tags and data in first-touch order
    step(OP_BEG, '0, '0);
    step(OP_ST, 32'h0840, 32'h5A);
    step(OP_ST, 32'h0880, 32'h77);
    check_outcome("R6 hidden before commit", 1'b1, 1'b0, 3'd0, 1'b0, 8'h00);
    step(OP_LD, 32'h08C0, '0);
    step(OP_ST, 32'h0845, 32'h66);
    step(OP_CM, '0, '0);
    check_outcome("R6 commit", 1'b0, 1'b0, 3'd0, 1'b1, 8'h03);
    chk("R3 tag slot0", "commit_tags", 64'(commit_tags[0 +: TAG_W]), 64'h21);
    chk("R3 tag slot1", "commit_tags", 64'(commit_tags[TAG_W +: TAG_W]), 64'h22);
    chk("R6 data slot0", "commit_data", 64'(commit_data[0 +: DATA_W]), 64'h66);
    chk("R6 data slot1", "commit_data", 64'(commit_data[DATA_W +: DATA_W]), 64'h77);
    @(negedge clk);
    check_outcome("R13 one-cycle commit", 1'b0, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R6 cleared data", "commit_data", 64'(commit_data[0 +: DATA_W]), 64'h0);

    // R12 lines of the committed transaction do not conflict afterwards
    step(OP_BEG, '0, '0);
    step(OP_SW, 32'h0880, '0);
    check_outcome("R12 no stale conflict", 1'b1, 1'b0, 3'd0, 1'b0, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule